// File: doc/BRIEF.md
# Pattern-Table Address Bit Generator

This block works out, dot by dot, the level of the pattern-table select address bit (A12) that a video processor drives onto its external memory bus. The bit does not always match bit 12 of the internal VRAM address register. While rendering is on, the external bit depends on which kind of fetch is in flight on the current dot. Name and attribute fetches drive it low. Background pattern fetches take the background table select. Sprite pattern fetches take either the sprite table select or, in tall-sprite mode, the low bit of the tile index of the sprite being fetched.

A mapper that counts rising edges of this bit, for example a scanline counter, can be fed from this output. It then sees the true bus activity and avoids the half-rate toggling of the internal register. The dot counter comes in from the video timing logic. The tile indices for the eight sprite slots of the line arrive as one preloaded flat vector. The result is registered once per dot clock.

Top module: `a12_gen`

## Requirements
- R1: While rst_ni is low, a12_o is 0.
- R2: a12_o is registered. After a rising clock edge it shows the value computed from the inputs sampled at that edge, and it holds that value until the next edge.
- R3: With render_en_i low, a12_o equals vaddr12_i, for any dot and any other input.
- R4: With rendering on, a12_o is 0 on name/attribute dots. These are the dots with (dot mod 8) < 4 in the ranges 0..255, 256..319 and 320..335, and every dot in 336..340.
- R5: With rendering on, a12_o equals bg_tbl_i on background pattern dots. These are the dots with (dot mod 8) >= 4 in 0..255 and 320..335.
- R6: With rendering on and spr_tall_i low, a12_o equals spr_tbl_i on sprite pattern dots. These are the dots with (dot mod 8) >= 4 in 256..319.
- R7: With rendering on and spr_tall_i high, a sprite pattern dot d drives a12_o to bit 0 of the tile index of slot k = (d-256)/8. That tile index is carried in tile_idx_i[8k+7:8k].
- R8: With rendering on, dots above 340 give a12_o = 0.
- R9: Take background table 0, sprite table 1, 8x8 sprites and rendering on. Then a12_o is 0 on dots 0..259. It is 1 on 260..263 and then alternates in 4-dot runs up to dot 319, and it is 0 on dots 320..340.
- R10: With rendering on, vaddr12_i has no effect on a12_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dot_i | input | 9 | Dot number within the scanline |
| render_en_i | input | 1 | Rendering enabled |
| bg_tbl_i | input | 1 | Background pattern-table select |
| spr_tbl_i | input | 1 | Sprite pattern-table select for 8x8 mode |
| spr_tall_i | input | 1 | 8x16 sprite mode |
| tile_idx_i | input | 64 | Tile index per sprite slot, slot k in bits 8k+7..8k |
| vaddr12_i | input | 1 | Bit 12 of the internal VRAM address |
| a12_o | output | 1 | External A12 for the current dot |

## Verification
A wrong fetch decode shows up on the first dot of the affected 4-dot run, one clock later. The symptom is a 1 where a 0 belongs, or the wrong select bit, so a full sweep of each line finds it within one scanline. A wrong sprite slot number leaves the mode-8x8 output correct. It only appears in tall mode, where neighbouring slots carry different tile low bits and so give a different level. Mistakes in selecting the source for disabled rendering show up on every dot as soon as vaddr12_i differs from the fetch-derived value.

// File: rtl/a12_pkg.sv
package a12_pkg;
  typedef enum logic [1:0] {
    FK_NONE   = 2'd0,
    FK_NAME   = 2'd1,
    FK_BG_PAT = 2'd2,
    FK_SP_PAT = 2'd3
  } fetch_kind_e;
endpackage

// File: rtl/a12_fetch_decode.sv
module a12_fetch_decode
  import a12_pkg::*;
#(
  parameter int DOT_W         = 9,
  parameter int VIS_DOTS      = 256,
  parameter int SLOT_DOTS     = 8,
  parameter int N_SLOTS       = 8,
  parameter int PRE_GROUPS    = 2,
  parameter int DOTS_PER_LINE = 341,
  localparam int SLOT_W       = $clog2(N_SLOTS)
) (
  input  logic [DOT_W-1:0]  dot_i,
  output fetch_kind_e       kind_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam int SPR_END  = VIS_DOTS + N_SLOTS * SLOT_DOTS;
  localparam int PRE_END  = SPR_END + PRE_GROUPS * SLOT_DOTS;
  localparam int HALF     = SLOT_DOTS / 2;
  localparam int LAST_DOT = DOTS_PER_LINE - 1;

  always_comb begin
    int d;
    int ofs;
    d      = int'(dot_i);
    ofs    = d % SLOT_DOTS;
    kind_o = FK_NONE;
    slot_o = '0;
    if (d < VIS_DOTS || (d >= SPR_END && d < PRE_END)) begin
      kind_o = (ofs >= HALF) ? FK_BG_PAT : FK_NAME;
    end else if (d < SPR_END) begin
      kind_o = (ofs >= HALF) ? FK_SP_PAT : FK_NAME;
      slot_o = SLOT_W'((d - VIS_DOTS) / SLOT_DOTS);
    end else if (d <= LAST_DOT) begin
      // trailing dummy name fetches
      kind_o = FK_NAME;
    end
  end
endmodule

// File: rtl/a12_src_mux.sv
module a12_src_mux
  import a12_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int TILE_W  = 8,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  fetch_kind_e               kind_i,
  input  logic [SLOT_W-1:0]         slot_i,
  input  logic                      bg_tbl_i,
  input  logic                      spr_tbl_i,
  input  logic                      spr_tall_i,
  input  logic [N_SLOTS*TILE_W-1:0] tile_idx_i,
  output logic                      a12_o
);
  logic [N_SLOTS-1:0] tile_lsb;
  logic               unused_tile_hi;

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_lsb
    assign tile_lsb[k] = tile_idx_i[k*TILE_W];
  end
  assign unused_tile_hi = ^tile_idx_i;

  always_comb begin
    unique case (kind_i)
      FK_BG_PAT: a12_o = bg_tbl_i;
      FK_SP_PAT: a12_o = spr_tall_i ? tile_lsb[slot_i] : spr_tbl_i;
      default:   a12_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/a12_gen.sv
module a12_gen
  import a12_pkg::*;
#(
  parameter int DOT_W         = 9,
  parameter int VIS_DOTS      = 256,
  parameter int SLOT_DOTS     = 8,
  parameter int N_SLOTS       = 8,
  parameter int PRE_GROUPS    = 2,
  parameter int DOTS_PER_LINE = 341,
  parameter int TILE_W        = 8,
  localparam int SLOT_W       = $clog2(N_SLOTS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [DOT_W-1:0]          dot_i,
  input  logic                      render_en_i,
  input  logic                      bg_tbl_i,
  input  logic                      spr_tbl_i,
  input  logic                      spr_tall_i,
  input  logic [N_SLOTS*TILE_W-1:0] tile_idx_i,
  input  logic                      vaddr12_i,
  output logic                      a12_o
);
  localparam int LAST_DOT = DOTS_PER_LINE - 1;

  fetch_kind_e       kind_w;
  logic [SLOT_W-1:0] slot_w;
  logic              fetch_a12;

  a12_fetch_decode #(
    .DOT_W(DOT_W), .VIS_DOTS(VIS_DOTS), .SLOT_DOTS(SLOT_DOTS),
    .N_SLOTS(N_SLOTS), .PRE_GROUPS(PRE_GROUPS), .DOTS_PER_LINE(DOTS_PER_LINE)
  ) u_dec (
    .dot_i (dot_i),
    .kind_o(kind_w),
    .slot_o(slot_w)
  );

  a12_src_mux #(
    .N_SLOTS(N_SLOTS), .TILE_W(TILE_W)
  ) u_mux (
    .kind_i    (kind_w),
    .slot_i    (slot_w),
    .bg_tbl_i  (bg_tbl_i),
    .spr_tbl_i (spr_tbl_i),
    .spr_tall_i(spr_tall_i),
    .tile_idx_i(tile_idx_i),
    .a12_o     (fetch_a12)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          a12_o <= 1'b0;
    else if (render_en_i) a12_o <= fetch_a12;
    else                  a12_o <= vaddr12_i;
  end

  // R3
  off_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !render_en_i |=> a12_o == $past(vaddr12_i));

  // R4
  name_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (render_en_i && kind_w == FK_NAME) |=> !a12_o);

  // R5
  bg_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (render_en_i && kind_w == FK_BG_PAT) |=> a12_o == $past(bg_tbl_i));

  // R6
  spr_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (render_en_i && kind_w == FK_SP_PAT && !spr_tall_i) |=> a12_o == $past(spr_tbl_i));

  // R7
  spr_tall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (render_en_i && kind_w == FK_SP_PAT && spr_tall_i)
      |=> a12_o == $past(tile_idx_i[slot_w*TILE_W]));

  // R8
  past_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (render_en_i && int'(dot_i) > LAST_DOT) |=> !a12_o);

  // R1
  always_comb begin
    if (!rst_ni) begin
      rst_low_chk: assert (a12_o == 1'b0 || $isunknown(a12_o));
    end
  end
endmodule

// File: tb/tb_a12_gen.sv
`timescale 1ns/1ps
module tb_a12_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [8:0]  dot_i = '0;
  logic        render_en_i = 1'b0;
  logic        bg_tbl_i = 1'b0;
  logic        spr_tbl_i = 1'b0;
  logic        spr_tall_i = 1'b0;
  logic [63:0] tile_idx_i = '0;
  logic        vaddr12_i = 1'b1;
  logic        a12_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  a12_gen dut (.*);

  function automatic logic exp_a12(int d, logic ren, logic bg, logic sp,
                                   logic tall, logic va, logic [63:0] tiles);
    if (!ren) return va;
    if (d < 256 || (d >= 320 && d < 336)) return (d % 8 >= 4) ? bg : 1'b0;
    if (d < 320) begin
      if (d % 8 < 4) return 1'b0;
      return tall ? tiles[((d - 256) / 8) * 8] : sp;
    end
    return 1'b0;
  endfunction

  function automatic string req_of(int d, logic ren, logic tall);
    if (!ren) return "R3";
    if (d > 340) return "R8";
    if (d >= 336 || d % 8 < 4) return "R4";
    if (d >= 256 && d < 320) return tall ? "R7" : "R6";
    return "R5";
  endfunction

  task automatic check(string req, logic act, logic exp, int d);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s dot=%0d actual=%0b expected=%0b", req, d, act, exp);
    end
  endtask

  initial begin
    #(4ns * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset holds output low even though vaddr12_i is high
    repeat (3) @(posedge clk_i);
    #1 check("R1", a12_o, 1'b0, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1 check("R3", a12_o, 1'b1, 0);

    // R2: no change between edges
    @(negedge clk_i) vaddr12_i = 1'b0;
    #1 check("R2", a12_o, 1'b1, 0);
    @(posedge clk_i); #1 check("R2", a12_o, 1'b0, 0);

    // full sweep over configs and dots
    for (int cfg = 0; cfg < 64; cfg++) begin
      logic [63:0] tiles;
      for (int k = 0; k < 8; k++) begin
        tiles[k*8 +: 8] = 8'(8'h5a + k * 37);
        tiles[k*8] = (cfg[5] ? 1'b1 : 1'b0) ^ 1'(k[0] ^ k[1]);
      end
      for (int d = 0; d < 352; d++) begin
        logic e;
        @(negedge clk_i);
        dot_i       = 9'(d);
        render_en_i = cfg[0];
        bg_tbl_i    = cfg[1];
        spr_tbl_i   = cfg[2];
        spr_tall_i  = cfg[3];
        vaddr12_i   = cfg[4] ^ 1'(d % 3 == 0); // R10: toggles while rendering
        tile_idx_i  = tiles;
        e = exp_a12(d, cfg[0], cfg[1], cfg[2], cfg[3], vaddr12_i, tiles);
        @(posedge clk_i); #1;
        check(req_of(d, cfg[0], cfg[3]), a12_o, e, d);
        if (cfg[0] && cfg[4]) check("R10", a12_o, e, d);
      end
    end

    // R9: stated waveform, bg=0 sp=1 8x8
    for (int d = 0; d < 341; d++) begin
      logic e;
      @(negedge clk_i);
      dot_i = 9'(d); render_en_i = 1'b1; bg_tbl_i = 1'b0;
      spr_tbl_i = 1'b1; spr_tall_i = 1'b0; vaddr12_i = 1'b1;
      e = (d >= 260 && d <= 319 && ((d - 260) / 4) % 2 == 0);
      @(posedge clk_i); #1;
      check("R9", a12_o, e, d);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule